// File: doc/BRIEF.md
# Bus Request/Grant Memory Master Handshake

This block lets a device borrow the host processor's address, data and control buses to run a single access to shared or external RAM. When an internal client asks for a transfer, the block latches the address, write data and direction, pulls its active-low bus request low and waits for the host to answer with an active-low grant. Once the grant has passed through a synchronizer, the block confirms ownership with an active-low acknowledge. It then runs one RAM cycle with chip select, output enable and write strobe, and hands the bus back.

The memory cycle has three phases. A setup cycle drives the address (and data, for a write) with chip select low. A strobe phase of a configurable length follows: for a write the write strobe is low, and for a read the returned word is captured on its last cycle. A hold cycle closes the access. Request and acknowledge are then released together in the same cycle as a one-cycle completion pulse, which also presents the word read. If the grant goes away while the block is still confirming ownership, the block falls back to requesting and starts no memory cycle. Once the acknowledge has been held into the setup cycle, the block keeps the bus until the access ends.

Top module: `busgrab_dma`

## Requirements
- R1: While reset is active, and until the first request after it, `breq_n`, `back_n`, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are all high (inactive) and `done` is low.
- R2: In the cycle after `xfer_req` is sampled high in idle, `breq_n` is low. It stays low without a break until the cycle in which `done` is high.
- R3: `back_n` goes low only while `breq_n` is low, and only after `grant_n` has been seen low. With a grant driven low and held, `back_n` is first seen low exactly SYNC_STAGES+1 clock cycles after the grant change.
- R4: If `grant_n` is back high by the time the acknowledge cycle is checked, `back_n` returns high after one cycle and `breq_n` stays low. No chip select, output enable or write strobe is produced. A later, held grant completes the transfer.
- R5: `mem_cs_n` is low only while `back_n` is low, for exactly STB_CYCLES+2 consecutive cycles per transfer.
- R6: On a read (`xfer_write` = 0), `mem_oe_n` is low for the same STB_CYCLES+2 cycles as `mem_cs_n`, and `mem_we_n` stays high. `mem_oe_n` and `mem_we_n` are never low together.
- R7: On a write (`xfer_write` = 1), `mem_we_n` is low for exactly STB_CYCLES cycles. It falls no earlier than one cycle after `mem_cs_n` falls and rises at least one cycle before `mem_cs_n` rises. `mem_oe_n` stays high.
- R8: While `mem_cs_n` is low, `mem_addr` and `mem_wdata` do not change, and `mem_addr` equals the `xfer_addr` latched when the request was accepted.
- R9: `breq_n` and `back_n` rise in the same cycle, and `done` is high for exactly that one cycle.
- R10: On a read, `rdata` carries the `mem_rdata` word sampled in the last strobe cycle and is valid while `done` is high.
- R11: A `xfer_req` pulse while a transfer is in progress is ignored. It does not change the address or data of the current access and does not start another request after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xfer_req | input | 1 | Transfer request from the internal client, sampled in idle |
| xfer_addr | input | ADDR_W | RAM word address for the transfer |
| xfer_wdata | input | DATA_W | Word to write |
| xfer_write | input | 1 | 1 = write, 0 = read |
| grant_n | input | 1 | Active-low bus grant from the host (asynchronous) |
| mem_rdata | input | DATA_W | Data returned by RAM during a read |
| breq_n | output | 1 | Active-low bus request |
| back_n | output | 1 | Active-low acknowledge of bus ownership |
| mem_cs_n | output | 1 | Active-low RAM chip select |
| mem_oe_n | output | 1 | Active-low RAM output enable |
| mem_we_n | output | 1 | Active-low RAM write strobe |
| mem_addr | output | ADDR_W | Address driven to RAM |
| mem_wdata | output | DATA_W | Data driven to RAM |
| rdata | output | DATA_W | Word captured by the last read |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is the fallback from the acknowledge cycle to requesting. It needs a grant that survives the synchronizer long enough to raise the acknowledge, but is gone again one cycle later. The bench drives `grant_n` low for exactly one clock, which after two synchronizer stages yields one cycle of acknowledge and then a withdrawn grant. It then confirms that no strobe appeared and that a later held grant still finishes the read. Stray requests during a transfer are injected while the block waits for a delayed grant, and the bench checks the RAM contents it models to show the stray address was never touched.

// File: rtl/busgrab_pkg.sv
package busgrab_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_ACK   = 3'd2,
    ST_SETUP = 3'd3,
    ST_STRB  = 3'd4,
    ST_HOLD  = 3'd5,
    ST_REL   = 3'd6
  } bg_state_e;

  typedef struct packed {
    logic breq_n;
    logic back_n;
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic done;
  } bg_pins_t;

  localparam bg_pins_t PINS_IDLE = '{breq_n: 1'b1, back_n: 1'b1, cs_n: 1'b1,
                                     oe_n: 1'b1, we_n: 1'b1, done: 1'b0};

  // Pin levels for each state; wr selects strobe versus output enable.
  function automatic bg_pins_t pins_of(bg_state_e s, logic wr);
    bg_pins_t p;
    p = PINS_IDLE;
    case (s)
      ST_REQ: p.breq_n = 1'b0;
      ST_ACK: begin
        p.breq_n = 1'b0;
        p.back_n = 1'b0;
      end
      ST_SETUP, ST_HOLD: begin
        p.breq_n = 1'b0;
        p.back_n = 1'b0;
        p.cs_n   = 1'b0;
        p.oe_n   = wr;
      end
      ST_STRB: begin
        p.breq_n = 1'b0;
        p.back_n = 1'b0;
        p.cs_n   = 1'b0;
        p.oe_n   = wr;
        p.we_n   = ~wr;
      end
      ST_REL: p.done = 1'b1;
      default: p = PINS_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/busgrab_rst_sync.sv
module busgrab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/busgrab_sync.sv
module busgrab_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] s_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q[0] <= RST_VAL;
        else        s_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q[i] <= RST_VAL;
        else        s_q[i] <= s_q[i-1];
      end
    end
  end

  assign q_out = s_q[STAGES-1];
endmodule

// File: rtl/busgrab_seq.sv
module busgrab_seq
  import busgrab_pkg::*;
#(
  parameter int STB_CYCLES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     granted,
  input  logic     wr_q,
  output bg_pins_t pins,
  output logic     cap_en,
  output logic     rd_cap
);
  localparam int CW = (STB_CYCLES > 1) ? $clog2(STB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STB_CYCLES - 1);

  bg_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           last_strb;
  bg_pins_t       pins_q, pins_d;

  assign last_strb = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_REQ;
      ST_REQ:   if (granted) state_d = ST_ACK;
      ST_ACK:   state_d = granted ? ST_SETUP : ST_REQ;
      ST_SETUP: state_d = ST_STRB;
      ST_STRB:  if (last_strb) state_d = ST_HOLD;
      ST_HOLD:  state_d = ST_REL;
      ST_REL:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_d  = (state_q == ST_STRB) ? cnt_q + 1'b1 : '0;
    pins_d = pins_of(state_d, wr_q);
  end

  assign cap_en = (state_q == ST_IDLE) && start;
  assign rd_cap = (state_q == ST_STRB) && last_strb && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pins_q  <= PINS_IDLE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pins_q  <= pins_d;
    end
  end

  assign pins = pins_q;
endmodule

// File: rtl/busgrab_dpath.sv
module busgrab_dpath #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              rd_cap,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_write,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (cap_en) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      wr_q    <= in_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_cap) rdata_q <= ram_rdata;
  end
endmodule

// File: rtl/busgrab_dma.sv
module busgrab_dma
  import busgrab_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int STB_CYCLES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_req,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [DATA_W-1:0] xfer_wdata,
  input  logic              xfer_write,
  input  logic              grant_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              breq_n,
  output logic              back_n,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic     srst_n;
  logic     grant_s_n;
  logic     cap_en, rd_cap, wr_q;
  bg_pins_t pins;

  busgrab_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  busgrab_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_gsync (
    .clk(clk), .rst_n(srst_n), .d_in(grant_n), .q_out(grant_s_n)
  );

  busgrab_seq #(.STB_CYCLES(STB_CYCLES)) u_seq (
    .clk(clk), .rst_n(srst_n), .start(xfer_req), .granted(~grant_s_n),
    .wr_q(wr_q), .pins(pins), .cap_en(cap_en), .rd_cap(rd_cap)
  );

  busgrab_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(srst_n), .cap_en(cap_en), .rd_cap(rd_cap),
    .in_addr(xfer_addr), .in_wdata(xfer_wdata), .in_write(xfer_write),
    .ram_rdata(mem_rdata), .addr_q(mem_addr), .wdata_q(mem_wdata),
    .wr_q(wr_q), .rdata_q(rdata)
  );

  assign breq_n   = pins.breq_n;
  assign back_n   = pins.back_n;
  assign mem_cs_n = pins.cs_n;
  assign mem_oe_n = pins.oe_n;
  assign mem_we_n = pins.we_n;
  assign done     = pins.done;
endmodule

// File: rtl/busgrab_dma_chk.sv
module busgrab_dma_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              breq_n,
  input logic              back_n,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              done
);
  // R3: acknowledge only while requesting
  p_ack_in_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !back_n |-> !breq_n);

  // R5: chip select only while the bus is owned
  p_cs_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !back_n);

  // R6: output enable and write strobe never overlap
  p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R7: strobe starts inside an already open chip select
  p_we_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!mem_cs_n && $past(!mem_cs_n)));

  // R7: strobe ends before chip select closes
  p_we_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> $past(mem_we_n));

  // R8: address and data hold still during the access
  p_bus_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  // R9: release of request and acknowledge together, with done
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(breq_n) |-> ($rose(back_n) && done));

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: acknowledge dropped while still requesting only when no access ran
  p_withdraw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(back_n) && !breq_n) |-> ($past(mem_cs_n) && mem_cs_n));
endmodule

bind busgrab_dma busgrab_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .breq_n(breq_n), .back_n(back_n),
  .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
);

// File: tb/tb_busgrab_dma.sv
module tb_busgrab_dma;
  localparam int AW  = 12;
  localparam int DW  = 16;
  localparam int STB = 2;
  localparam int SYN = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          xfer_req, xfer_write, grant_n;
  logic [AW-1:0] xfer_addr;
  logic [DW-1:0] xfer_wdata;
  logic [DW-1:0] mem_rdata;
  logic          breq_n, back_n, mem_cs_n, mem_oe_n, mem_we_n, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rdata;

  int checks = 0;
  int errors = 0;
  bit ready  = 1'b0;

  logic [DW-1:0] ram [16];

  always #4 clk = ~clk;

  busgrab_dma #(.ADDR_W(AW), .DATA_W(DW), .STB_CYCLES(STB), .SYNC_STAGES(SYN)) dut (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_addr(xfer_addr),
    .xfer_wdata(xfer_wdata), .xfer_write(xfer_write), .grant_n(grant_n),
    .mem_rdata(mem_rdata), .breq_n(breq_n), .back_n(back_n),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rdata(rdata), .done(done)
  );

  // RAM model: write on the rising edge of the strobe, read while enabled
  always @(posedge mem_we_n) if (ready && !mem_cs_n) ram[mem_addr[3:0]] <= mem_wdata;
  assign mem_rdata = mem_oe_n ? '0 : ram[mem_addr[3:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // results of one observed transfer
  int n_cs, n_we, n_oe, n_done, grant_iter, ack_iter;
  bit we_first, we_last, moved, cs_no_ack, rel_ok, req_gap, breq_first, early_ack;
  logic [AW-1:0] addr_seen;
  logic [DW-1:0] rd_seen;

  task automatic observe(input int gdelay, input bit inject);
    int  gc = 0;
    int  post = 0;
    bit  fin = 0, prev_cs = 1, prev_we = 1, granted = 0;
    logic [AW-1:0] pa = '0;
    logic [DW-1:0] pd = '0;
    n_cs = 0; n_we = 0; n_oe = 0; n_done = 0; grant_iter = -1; ack_iter = -1;
    we_first = 0; we_last = 0; moved = 0; cs_no_ack = 0; rel_ok = 0;
    req_gap = 0; breq_first = 1; early_ack = 0; addr_seen = '0; rd_seen = '0;
    for (int c = 0; c < 300 && post < 3; c++) begin
      @(negedge clk);
      if (c == 0) begin
        breq_first = breq_n;
        xfer_req   = 1'b0;
      end
      if (inject && c == 2) begin
        xfer_req = 1'b1; xfer_addr = 12'd9; xfer_wdata = 16'hFFFF; xfer_write = 1'b1;
      end
      if (inject && c == 3) xfer_req = 1'b0;
      if (!back_n && !granted) early_ack = 1;
      if (!back_n && ack_iter < 0) ack_iter = c;
      if (!mem_cs_n) begin
        n_cs++;
        if (prev_cs) begin we_first = mem_we_n; addr_seen = mem_addr; end
        else if (mem_addr !== pa || mem_wdata !== pd) moved = 1;
        if (back_n) cs_no_ack = 1;
        pa = mem_addr; pd = mem_wdata;
      end
      if (mem_cs_n && !prev_cs) we_last = prev_we;
      if (!mem_we_n) n_we++;
      if (!mem_oe_n) n_oe++;
      if (!fin && breq_n && !done) req_gap = 1;
      if (done) begin
        n_done++; rd_seen = rdata; fin = 1;
        if (breq_n && back_n) rel_ok = 1;
      end
      if (fin) post++;
      prev_cs = mem_cs_n; prev_we = mem_we_n;
      if (!breq_n) begin
        gc++;
        if (gc > gdelay && !granted) begin grant_n = 1'b0; granted = 1; grant_iter = c; end
      end else begin
        gc = 0; grant_n = 1'b1;
      end
    end
    grant_n = 1'b1;
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    xfer_req = 1'b1; xfer_write = wr; xfer_addr = a; xfer_wdata = d;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; xfer_req = 1'b0; xfer_write = 1'b0; xfer_addr = '0;
    xfer_wdata = '0; grant_n = 1'b1;
    for (int i = 0; i < 16; i++) ram[i] = 16'h5000 + 16'(i);
    repeat (3) @(negedge clk);
    chk({breq_n, back_n, mem_cs_n, mem_oe_n, mem_we_n, done} == 6'b111110, "R1 reset pins",
        {breq_n, back_n, mem_cs_n, mem_oe_n, mem_we_n, done}, 6'b111110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ready = 1'b1;
    chk({breq_n, back_n, mem_cs_n, done} == 4'b1110, "R1 idle after reset",
        {breq_n, back_n, mem_cs_n, done}, 4'b1110);
  endtask

  task automatic t_write_basic();
    issue(1'b1, 12'd3, 16'hA5C3);
    observe(0, 1'b0);
    chk(breq_first == 1'b0, "R2 request next cycle", breq_first, 0);
    chk(!req_gap, "R2 request held", req_gap, 0);
    chk(n_cs == STB + 2 && !cs_no_ack, "R5 cs length", n_cs, STB + 2);
    chk(n_we == STB, "R7 strobe length", n_we, STB);
    chk(we_first && we_last, "R7 strobe inside cs", {we_first, we_last}, 2'b11);
    chk(n_oe == 0, "R7 oe idle on write", n_oe, 0);
    chk(!moved && addr_seen == 12'd3, "R8 address stable", addr_seen, 3);
    chk(rel_ok && n_done == 1, "R9 release with done", n_done, 1);
    chk(ram[3] == 16'hA5C3, "R7 word written", ram[3], 16'hA5C3);
  endtask

  task automatic t_read_delayed();
    issue(1'b0, 12'd3, 16'h0000);
    observe(3, 1'b0);
    chk(!early_ack, "R3 no ack before grant", early_ack, 0);
    chk(ack_iter - grant_iter == SYN + 1, "R3 grant latency", ack_iter - grant_iter, SYN + 1);
    chk(n_oe == STB + 2 && n_we == 0, "R6 read enables", n_oe, STB + 2);
    chk(rd_seen == 16'hA5C3, "R10 read data", rd_seen, 16'hA5C3);
  endtask

  task automatic t_ignore_busy();
    issue(1'b1, 12'd7, 16'h1234);
    observe(5, 1'b1);
    chk(addr_seen == 12'd7 && n_done == 1, "R11 current access kept", addr_seen, 7);
    begin
      int lows = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!breq_n) lows++;
      end
      chk(lows == 0, "R11 no second request", lows, 0);
    end
    chk(ram[9] == 16'h5009, "R11 stray address untouched", ram[9], 16'h5009);
    issue(1'b0, 12'd7, 16'h0000);
    observe(1, 1'b0);
    chk(rd_seen == 16'h1234, "R10 readback of second write", rd_seen, 16'h1234);
  endtask

  task automatic t_withdraw();
    int ack_lows = 0, cs_lows = 0, breq_highs = 0;
    issue(1'b0, 12'd5, 16'h0000);
    @(negedge clk);
    xfer_req = 1'b0;
    grant_n  = 1'b0;
    @(negedge clk);
    grant_n  = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!back_n) ack_lows++;
      if (!mem_cs_n || !mem_oe_n || !mem_we_n) cs_lows++;
      if (breq_n) breq_highs++;
    end
    chk(ack_lows == 1, "R4 one ack cycle", ack_lows, 1);
    chk(cs_lows == 0, "R4 no memory cycle", cs_lows, 0);
    chk(breq_highs == 0, "R4 request kept", breq_highs, 0);
    observe(0, 1'b0);
    chk(n_done == 1 && rd_seen == 16'h5005, "R4 completes after regrant", rd_seen, 16'h5005);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_write_basic();
    t_read_delayed();
    t_ignore_busy();
    t_withdraw();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule